// File: doc/BRIEF.md
# PHY Control-Port Handshake Master

This block reaches a PHY register space that is addressed indirectly, with 16-bit addresses and 16-bit data. It presents a 20-bit control word to the PHY. It reads back a 17-bit status word that holds an acknowledge flag and 16 bits of read data. A requester issues one read or write at a time. It supplies an address, write data and a direction flag. It gets back read data, a one-cycle completion pulse and a timeout flag.

Each transaction is built from handshake phases. In every phase the master raises one strobe and waits for the acknowledge to go high. It then removes the strobe and waits for the acknowledge to go low. Only after that does the next phase start.

The order of phases is fixed:
- A transaction always starts with an address-capture phase.
- A write then runs a data-capture phase and a write-strobe phase.
- A read runs one read-strobe phase and latches the returned data while the acknowledge is high.

Every wait polls the synchronized acknowledge at most ten times, with a programmable gap between polls. If the expected level does not arrive, the transaction is abandoned and a timeout is reported.

Top module: `phy_ctl_master`

## Requirements
- R1: Control word layout: bits 15:0 carry the address or data, bit 16 is address capture, bit 17 is data capture, bit 18 is the write strobe and bit 19 is the read strobe. At most one of bits 19:16 is ever high.
- R2: Status word layout: bit 16 is the acknowledge and bits 15:0 are read data. A read returns bits 15:0 of the status as they stood while the acknowledge was high.
- R3: Every transaction begins with the address phase. The master shows the bare address in the cycle after acceptance, then address plus bit 16 until the acknowledge is high, then the bare address until the acknowledge is low.
- R4: A write continues with three more steps. First it shows the bare data, then data plus bit 17 until the acknowledge is high, then the bare data until the acknowledge is low. Next it shows bit 18 alone until the acknowledge is high, then the bare data until the acknowledge is low. Finally the control word returns to zero.
- R5: A read continues with bit 19 alone until the acknowledge is high. At that point it latches the read data, drives the control word to zero and waits for the acknowledge to be low.
- R6: Each acknowledge wait takes at most 10 polls, one every poll_gap_i+1 cycles, with the first poll poll_gap_i+1 cycles after the wait begins. On an unresponsive PHY the completion comes exactly 1+10*(poll_gap_i+1) cycles after acceptance.
- R7: On a timeout, done_o and timeout_o pulse together, the control word returns to zero and the master becomes idle again.
- R8: req_ready_o is high only while idle, and a request is taken only then. A request raised during a transaction has no effect on the control sequence or on the PHY contents.
- R9: done_o lasts exactly one cycle. rdata_o changes only when a read latches its data, so a write or a timeout leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | PHY register address |
| req_wdata_i | input | 16 | Write data |
| poll_gap_i | input | 8 | Idle cycles between acknowledge polls |
| req_ready_o | output | 1 | Master idle, request can be taken |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Set with done_o when a wait expired |
| rdata_o | output | 16 | Data of the last successful read |
| ctl_o | output | 20 | Control word to the PHY |
| stat_i | input | 17 | Status word from the PHY |

## Verification
The bench drives the master against a PHY model with a small register array.

Random reads and writes use random addresses, data, poll gaps and acknowledge delays. These runs show whether the control-word sequence and the read-back values match a shadow copy. They also catch cases where address and data values coincide, so that consecutive control words do not change.

A PHY that never acknowledges separates the poll counting and gap timing by the exact completion latency. An acknowledge stuck high shows the same timeout taken on a falling-edge wait.

Requests raised mid-transaction and a write followed by a read of a different register show that nothing leaks into a running transaction and that rdata_o holds its value.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  localparam int DATA_W      = 16;
  localparam int CTL_W       = 20;
  localparam int STAT_W      = 17;
  localparam int CAP_ADR_BIT = 16;
  localparam int CAP_DAT_BIT = 17;
  localparam int WR_BIT      = 18;
  localparam int RD_BIT      = 19;
  localparam int ACK_BIT     = 16;

  typedef enum logic [3:0] {
    ST_IDLE, ST_A_SET, ST_A_CAP, ST_A_REL,
    ST_D_SET, ST_D_CAP, ST_D_REL, ST_W_STB, ST_W_REL,
    ST_R_STB, ST_R_REL
  } step_e;
endpackage

// File: rtl/phy_ack_sync.sv
module phy_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/phy_ack_poll.sv
module phy_ack_poll #(
  parameter int GAP_W     = 8,
  parameter int MAX_POLLS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             ack_i,
  input  logic             expect_i,
  output logic             hit_o,
  output logic             expire_o
);
  localparam int PW = $clog2(MAX_POLLS + 1);

  logic [GAP_W-1:0] gap_cnt_q;
  logic [PW-1:0]    poll_cnt_q;
  logic             tick;

  assign tick     = en_i && (gap_cnt_q == gap_i);
  assign hit_o    = tick && (ack_i == expect_i);
  assign expire_o = tick && (ack_i != expect_i) && (poll_cnt_q == PW'(MAX_POLLS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_cnt_q  <= '0;
      poll_cnt_q <= '0;
    end else begin
      gap_cnt_q <= (!en_i || tick) ? '0 : gap_cnt_q + 1'b1;
      if (!en_i || hit_o || expire_o) poll_cnt_q <= '0;
      else if (tick)                  poll_cnt_q <= poll_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/phy_ctl_master.sv
module phy_ctl_master
  import phy_ctl_pkg::*;
#(
  parameter int GAP_W       = 8,
  parameter int MAX_POLLS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [GAP_W-1:0]  poll_gap_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CTL_W-1:0]  ctl_o,
  input  logic [STAT_W-1:0] stat_i
);
  step_e             state_q, state_d;
  logic [DATA_W-1:0] addr_q, data_q, rdata_q;
  logic              write_q, done_q, err_q;
  logic              ack_s, wait_en, exp_lvl, hit, expire;

  phy_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(stat_i[ACK_BIT]), .q_o(ack_s)
  );

  phy_ack_poll #(.GAP_W(GAP_W), .MAX_POLLS(MAX_POLLS)) u_poll (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(wait_en), .gap_i(poll_gap_i),
    .ack_i(ack_s), .expect_i(exp_lvl), .hit_o(hit), .expire_o(expire)
  );

  always_comb begin
    state_d = state_q;
    wait_en = 1'b0;
    exp_lvl = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = ST_A_SET;
      ST_A_SET: state_d = ST_A_CAP;
      ST_A_CAP: begin wait_en = 1'b1; exp_lvl = 1'b1; if (hit) state_d = ST_A_REL; end
      ST_A_REL: begin wait_en = 1'b1; if (hit) state_d = write_q ? ST_D_SET : ST_R_STB; end
      ST_D_SET: state_d = ST_D_CAP;
      ST_D_CAP: begin wait_en = 1'b1; exp_lvl = 1'b1; if (hit) state_d = ST_D_REL; end
      ST_D_REL: begin wait_en = 1'b1; if (hit) state_d = ST_W_STB; end
      ST_W_STB: begin wait_en = 1'b1; exp_lvl = 1'b1; if (hit) state_d = ST_W_REL; end
      ST_W_REL: begin wait_en = 1'b1; if (hit) state_d = ST_IDLE; end
      ST_R_STB: begin wait_en = 1'b1; exp_lvl = 1'b1; if (hit) state_d = ST_R_REL; end
      ST_R_REL: begin wait_en = 1'b1; if (hit) state_d = ST_IDLE; end
      default:  state_d = ST_IDLE;
    endcase
    if (expire) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      write_q <= 1'b0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        addr_q  <= req_addr_i;
        data_q  <= req_wdata_i;
        write_q <= req_write_i;
      end
      if (state_q == ST_R_STB && hit) rdata_q <= stat_i[DATA_W-1:0];
      done_q <= expire || (hit && (state_q == ST_W_REL || state_q == ST_R_REL));
      err_q  <= expire;
    end
  end

  always_comb begin
    ctl_o = '0;
    unique case (state_q)
      ST_A_SET, ST_A_REL:           ctl_o[DATA_W-1:0] = addr_q;
      ST_A_CAP: begin               ctl_o[DATA_W-1:0] = addr_q; ctl_o[CAP_ADR_BIT] = 1'b1; end
      ST_D_SET, ST_D_REL, ST_W_REL: ctl_o[DATA_W-1:0] = data_q;
      ST_D_CAP: begin               ctl_o[DATA_W-1:0] = data_q; ctl_o[CAP_DAT_BIT] = 1'b1; end
      ST_W_STB:                     ctl_o[WR_BIT] = 1'b1;
      ST_R_STB:                     ctl_o[RD_BIT] = 1'b1;
      default:                      ctl_o = '0;
    endcase
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = done_q;
  assign timeout_o   = err_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/phy_ctl_master_chk.sv
module phy_ctl_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [15:0] req_addr_i,
  input logic        req_ready_o,
  input logic        done_o,
  input logic        timeout_o,
  input logic [15:0] rdata_o,
  input logic [19:0] ctl_o
);
  p_one_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ctl_o[19:16]));

  p_addr_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (ctl_o == {4'b0000, $past(req_addr_i)}));

  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (ctl_o == 20'h0));

  p_err_with_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (done_o && req_ready_o));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ctl_o[19]) |-> $stable(rdata_o));
endmodule

bind phy_ctl_master phy_ctl_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_addr_i(req_addr_i), .req_ready_o(req_ready_o), .done_o(done_o),
  .timeout_o(timeout_o), .rdata_o(rdata_o), .ctl_o(ctl_o)
);

// File: tb/phy_ctl_master_bench.sv
module phy_ctl_master_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [7:0]  poll_gap_i = '0;
  logic        req_ready_o, done_o, timeout_o;
  logic [15:0] rdata_o;
  logic [19:0] ctl_o;
  logic [16:0] stat_i;

  int tests = 0;
  int fails = 0;

  always #2.5 clk_i = ~clk_i;

  phy_ctl_master u_phy_ctl_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .req_write_i(req_write_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .poll_gap_i(poll_gap_i),
    .req_ready_o(req_ready_o), .done_o(done_o), .timeout_o(timeout_o),
    .rdata_o(rdata_o), .ctl_o(ctl_o), .stat_i(stat_i)
  );

  // PHY model: 0 normal, 1 never acks, 2 ack stuck high
  int          mode = 0;
  int          dly = 0;
  int          dcnt = 0;
  logic        ack = 1'b0;
  logic [15:0] p_addr = '0, p_data = '0, p_rd = '0;
  logic [15:0] pmem [16];
  logic [15:0] shadow [16];
  logic        strobe;

  assign strobe = |ctl_o[19:16];
  assign stat_i = {ack, p_rd};

  always @(posedge clk_i) begin
    if (mode == 1)      ack <= 1'b0;
    else if (mode == 2) ack <= 1'b1;
    else if (strobe != ack) begin
      if (dcnt >= dly) begin
        ack  <= strobe;
        dcnt <= 0;
        if (strobe) begin
          if (ctl_o[16]) p_addr <= ctl_o[15:0];
          if (ctl_o[17]) p_data <= ctl_o[15:0];
          if (ctl_o[18]) pmem[p_addr[3:0]] <= p_data;
          if (ctl_o[19]) p_rd <= pmem[p_addr[3:0]];
        end
      end else dcnt <= dcnt + 1;
    end else dcnt <= 0;
  end

  // control-word change monitor
  logic [19:0] mon [16];
  int          mon_len = 0;
  logic [19:0] mon_prev = '0;
  always @(negedge clk_i) begin
    if (ctl_o != mon_prev) begin
      if (mon_len < 16) mon[mon_len] = ctl_o;
      mon_len = mon_len + 1;
      mon_prev = ctl_o;
    end
  end

  logic [19:0] exp_seq [16];
  int          exp_len;

  task automatic push(input logic [19:0] v, inout logic [19:0] last);
    if (v != last) begin
      exp_seq[exp_len] = v;
      exp_len++;
      last = v;
    end
  endtask

  // kind: 0 ok, 1 dead PHY, 2 ack stuck high
  task automatic build_seq(input bit wr, input logic [15:0] a, input logic [15:0] d, input int kind);
    logic [19:0] last = 20'h0;
    exp_len = 0;
    push({4'h0, a}, last);
    push({4'h1, a}, last);
    if (kind == 1) begin push(20'h0, last); return; end
    push({4'h0, a}, last);
    if (kind == 2) begin push(20'h0, last); return; end
    if (wr) begin
      push({4'h0, d}, last); push({4'h2, d}, last); push({4'h0, d}, last);
      push(20'h40000, last); push({4'h0, d}, last); push(20'h0, last);
    end else begin
      push(20'h80000, last); push(20'h0, last);
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_seq(input string req);
    bit ok = (mon_len == exp_len);
    for (int i = 0; i < 16; i++)
      if (ok && i < exp_len && mon[i] != exp_seq[i]) ok = 0;
    chk(ok, req, mon_len, exp_len);
  endtask

  // issue one request, return completion latency in edges after acceptance
  task automatic txn(input bit wr, input logic [15:0] a, input logic [15:0] d,
                     output bit err, output int lat);
    @(negedge clk_i);
    mon_len = 0;
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = a; req_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 5000) begin @(negedge clk_i); lat++; end
    err = timeout_o;
    @(negedge clk_i);
    chk(!done_o, "R9 done pulse width", done_o, 0);
  endtask

  task automatic settle();
    repeat (12) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit err;
    int lat;
    logic [15:0] a, d, last_rd;
    void'($urandom(32'h1d5e));
    for (int i = 0; i < 16; i++) begin pmem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk_i);
    chk(ctl_o == 0 && req_ready_o && !done_o && !timeout_o && rdata_o == 0,
        "reset state", {ctl_o[15:0], rdata_o}, 0);
    rst_ni = 1'b1;
    settle();

    // directed: coinciding address and data, gap 0
    build_seq(1, 16'h0005, 16'h0005, 0);
    txn(1, 16'h0005, 16'h0005, err, lat);
    shadow[5] = 16'h0005;
    chk(!err, "R4 write ok", err, 0);
    chk_seq("R1 R3 R4 write sequence a==d");
    build_seq(0, 16'h0005, 16'h0, 0);
    txn(0, 16'h0005, 16'h0, err, lat);
    chk(rdata_o == 16'h0005, "R2 R5 read back", rdata_o, 16'h0005);
    chk_seq("R1 R3 R5 read sequence");
    last_rd = rdata_o;

    // random mix
    for (int n = 0; n < 40; n++) begin
      bit wr = $urandom % 2;
      a = $urandom; d = $urandom;
      poll_gap_i = $urandom % 4;
      dly = $urandom % 4;
      build_seq(wr, a, d, 0);
      txn(wr, a, d, err, lat);
      chk(!err, "R6 no timeout on live PHY", err, 0);
      chk_seq(wr ? "R1 R3 R4 random write sequence" : "R1 R3 R5 random read sequence");
      if (wr) begin
        shadow[a[3:0]] = d;
        chk(rdata_o == last_rd, "R9 rdata held over write", rdata_o, last_rd);
      end else begin
        chk(rdata_o == shadow[a[3:0]], "R2 R5 random read data", rdata_o, shadow[a[3:0]]);
        last_rd = rdata_o;
      end
      settle();
    end

    // dead PHY: exact timeout latency, gaps 0 and 3
    dly = 0;
    for (int g = 0; g < 4; g += 3) begin
      poll_gap_i = 8'(g);
      mode = 1;
      build_seq(1, 16'h00a3, 16'hbeef, 1);
      txn(1, 16'h00a3, 16'hbeef, err, lat);
      chk(lat == 1 + 10 * (g + 1), "R6 timeout latency", lat, 1 + 10 * (g + 1));
      chk(err, "R7 timeout flagged", err, 1);
      chk(ctl_o == 0 && req_ready_o, "R7 idle after timeout", ctl_o, 0);
      chk_seq("R7 dead PHY sequence");
      chk(rdata_o == last_rd, "R9 rdata held over timeout", rdata_o, last_rd);
      mode = 0;
      settle();
    end

    // ack stuck high: falling wait expires
    poll_gap_i = 1;
    mode = 2;
    settle();
    build_seq(0, 16'h0042, 16'h0, 2);
    txn(0, 16'h0042, 16'h0, err, lat);
    chk(err, "R7 stuck-high timeout", err, 1);
    chk_seq("R3 R7 stuck-high sequence");
    chk(rdata_o == last_rd, "R9 rdata held on failed read", rdata_o, last_rd);
    mode = 0;
    settle();

    // requests while busy are ignored
    poll_gap_i = 0;
    dly = 2;
    a = 16'h0007; d = 16'h1234;
    build_seq(1, a, d, 0);
    @(negedge clk_i);
    mon_len = 0;
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = a; req_wdata_i = d;
    @(negedge clk_i);
    req_addr_i = 16'h0009; req_wdata_i = 16'hdead;
    chk(!req_ready_o, "R8 ready low while busy", req_ready_o, 0);
    lat = 0;
    while (!done_o && lat < 5000) begin @(negedge clk_i); lat++; end
    req_valid_i = 1'b0;
    shadow[7] = d;
    chk(!timeout_o, "R8 first write completes", timeout_o, 0);
    @(negedge clk_i);
    chk_seq("R8 sequence unaffected by busy request");
    settle();
    build_seq(0, 16'h0009, 16'h0, 0);
    txn(0, 16'h0009, 16'h0, err, lat);
    chk(rdata_o == shadow[9], "R8 ignored write left PHY alone", rdata_o, shadow[9]);
    txn(0, 16'h0007, 16'h0, err, lat);
    chk(rdata_o == 16'h1234, "R2 R5 read of busy-test write", rdata_o, 16'h1234);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule